// File: doc/BRIEF.md
# Windowed Watchdog Timer with Keyed Service

This block is a windowed watchdog on a simple 32-bit register bus. Software starts it by writing a fixed arming word. The down-counter then loads from a coarse preload field shifted left by a fixed amount and counts one step per clock. Once started, software cannot stop it. To keep the system alive, software sends a two-word service key. The pair is accepted only while the counter sits inside an open window at the tail of the period. A pair that arrives too early is a violation, and so is a counter that reaches zero unserviced.

On a violation the block sets a sticky status flag. It also emits a one-cycle pulse on either a reset-request output or a non-maskable-interrupt output, depending on the reaction setting. It then reloads and keeps running. Preload, window and reaction settings are sampled only when the counter reloads, so a change never disturbs the period already in progress. The register offsets on the bus are fixed so that existing software can drive the block.

Top module: `win_wdog`

## Requirements
- R1: Writing exactly 0xA98559DA to offset 0x90 starts the watchdog. Any other value does not start it. Offset 0x90 reads back 0xA98559DA while running and 0 while stopped. No write stops it once it is running.
- R2: Offset 0x94 holds a 12-bit preload field in bits [11:0]; wider bits are dropped. The reload value is that field shifted left by PRE_SHIFT. The counter loads on start and then decrements by one each clock. Its value reads at offset 0xA0.
- R3: One service is the word 0xE51A written to offset 0x9C followed by 0xA35C. Any key write that breaks this order sends the tracker back to expecting 0xE51A and does not reload the counter.
- R4: The window code at offset 0xA8 selects the window threshold as the reload value shifted right by k. The codes are 0x50 (k=1), 0x500 (k=2), 0x5000 (k=3), 0x50000 (k=4) and 0x500000 (k=5); any other code acts as k=1. A completed pair while the counter is at or below the threshold reloads the counter with no violation.
- R5: A completed pair while the counter is above the threshold is an early-service violation, and the counter reloads.
- R6: A counter at zero with no pair completing on that edge is an expiry violation, and the counter reloads. A pair completing on that same edge is a valid service instead.
- R7: A violation gives a one-cycle pulse in the following cycle. The pulse goes to nmi_req when the latched reaction word (offset 0xA4) equals 0xA, and to rst_req otherwise. The two outputs are never high together.
- R8: Status bit 1 (offset 0x98) is set by any violation and cleared by writing 1 to it. Writing 0 leaves it unchanged.
- R9: Preload, window and reaction writes take effect at the next reload, not at once.
- R10: After reset the block is stopped: counter 0, status 0, both request outputs low, preload 0xFFF, window code 0x50, reaction 0.
- R11: A key pair sent while the watchdog is stopped has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Byte offset for read and write |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for bus_addr (combinational) |
| rst_req | output | 1 | One-cycle reset request on violation |
| nmi_req | output | 1 | One-cycle non-maskable interrupt request on violation |

## Verification
The hardest case to reach is a pair whose second word lands exactly on the window threshold, or on the zero count, because the decision rests on the counter value at one single edge. The bench uses a short shift so that periods are a few dozen cycles. It arms the block, sends the first key word, then waits a count of cycles computed from each table entry so that the closing word meets a chosen counter value: one above the threshold, equal to it, or zero. A second directed sequence changes the reaction word mid-period, so that two expiries in a row show the old routing and then the new one.

// File: rtl/win_wdog_pkg.sv
package win_wdog_pkg;
   // Register byte offsets, fixed for software compatibility
   localparam logic [7:0] OFF_CTL   = 8'h90;
   localparam logic [7:0] OFF_PRE   = 8'h94;
   localparam logic [7:0] OFF_STAT  = 8'h98;
   localparam logic [7:0] OFF_KEY   = 8'h9C;
   localparam logic [7:0] OFF_CNT   = 8'hA0;
   localparam logic [7:0] OFF_REACT = 8'hA4;
   localparam logic [7:0] OFF_WIN   = 8'hA8;

   localparam logic [31:0] ARM_WORD  = 32'hA98559DA;
   localparam logic [31:0] SVC_FIRST = 32'h0000E51A;
   localparam logic [31:0] SVC_LAST  = 32'h0000A35C;
   localparam logic [31:0] NMI_WORD  = 32'h0000000A;
   localparam logic [31:0] WIN_RESET = 32'h00000050;

   typedef enum logic {SEQ_WAIT_FIRST, SEQ_WAIT_LAST} seq_t;
endpackage

// File: rtl/win_wdog_keyseq.sv
module win_wdog_keyseq
   import win_wdog_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              key_we,
   input  logic [DATA_W-1:0] key_data,
   output logic              pair_done
);
   localparam logic [DATA_W-1:0] K_FIRST = DATA_W'(SVC_FIRST);
   localparam logic [DATA_W-1:0] K_LAST  = DATA_W'(SVC_LAST);

   seq_t state_q;

   assign pair_done = key_we && (state_q == SEQ_WAIT_LAST) && (key_data == K_LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SEQ_WAIT_FIRST;
      end else if (key_we) begin
         if (state_q == SEQ_WAIT_FIRST && key_data == K_FIRST)
            state_q <= SEQ_WAIT_LAST;
         else
            state_q <= SEQ_WAIT_FIRST;   // completion or broken order
      end
   end
endmodule

// File: rtl/win_wdog_window.sv
module win_wdog_window #(
   parameter int CNT_W  = 25,
   parameter int DATA_W = 32,
   parameter int NCODES = 5
) (
   input  logic [DATA_W-1:0] win_code,
   input  logic [CNT_W-1:0]  reload_val,
   output logic [CNT_W-1:0]  thresh
);
   logic [NCODES-1:0] hit;

   for (genvar i = 0; i < NCODES; i++) begin : g_code
      localparam logic [DATA_W-1:0] CODE = DATA_W'(5) << (4 * (i + 1));
      assign hit[i] = (win_code == CODE);
   end

   always_comb begin
      thresh = reload_val >> 1;   // unknown codes fall back to the widest window
      for (int i = 0; i < NCODES; i++) begin
         if (hit[i]) thresh = reload_val >> (i + 1);
      end
   end
endmodule

// File: rtl/win_wdog_core.sv
module win_wdog_core #(
   parameter int CNT_W = 25
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             arm,
   input  logic             pair_done,
   input  logic [CNT_W-1:0] reload_val,
   input  logic [CNT_W-1:0] thresh,
   output logic             running,
   output logic [CNT_W-1:0] cnt,
   output logic             reload_ev,
   output logic             viol_ev
);
   logic start, expire, early, good;

   assign start     = arm && !running;
   assign expire    = running && (cnt == '0) && !pair_done;
   assign early     = running && pair_done && (cnt > thresh);
   assign good      = running && pair_done && (cnt <= thresh);
   assign viol_ev   = expire || early;
   assign reload_ev = start || good || viol_ev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         running <= 1'b0;
         cnt     <= '0;
      end else begin
         if (start) running <= 1'b1;
         if (reload_ev)
            cnt <= reload_val;
         else if (running)
            cnt <= cnt - 1'b1;
      end
   end
endmodule

// File: rtl/win_wdog.sv
module win_wdog
   import win_wdog_pkg::*;
#(
   parameter int ADDR_W    = 8,
   parameter int DATA_W    = 32,
   parameter int PRE_W     = 12,
   parameter int PRE_SHIFT = 13,
   parameter int NCODES    = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              rst_req,
   output logic              nmi_req
);
   localparam int CNT_W = PRE_W + PRE_SHIFT;

   if (ADDR_W < 8) begin : g_bad_addr
      $error("win_wdog: ADDR_W must cover offset 0xA8");
   end
   if (DATA_W < 32) begin : g_bad_data
      $error("win_wdog: DATA_W must hold the 32-bit key words");
   end
   if (CNT_W > DATA_W) begin : g_bad_cnt
      $error("win_wdog: counter does not fit the read bus");
   end
   if (4 * (NCODES + 1) > DATA_W) begin : g_bad_codes
      $error("win_wdog: window codes do not fit the data word");
   end

   logic [PRE_W-1:0]  pre_q;
   logic [DATA_W-1:0] win_q, react_q;
   logic              stat_q, nmi_sel_q;
   logic [CNT_W-1:0]  thr_q, thr_live, reload_val, cnt;
   logic              running, reload_ev, viol_ev, pair_done;
   logic              sel_ctl, sel_pre, sel_stat, sel_key, sel_react, sel_win;

   assign sel_ctl   = bus_addr == ADDR_W'(OFF_CTL);
   assign sel_pre   = bus_addr == ADDR_W'(OFF_PRE);
   assign sel_stat  = bus_addr == ADDR_W'(OFF_STAT);
   assign sel_key   = bus_addr == ADDR_W'(OFF_KEY);
   assign sel_react = bus_addr == ADDR_W'(OFF_REACT);
   assign sel_win   = bus_addr == ADDR_W'(OFF_WIN);

   assign reload_val = CNT_W'(pre_q) << PRE_SHIFT;

   win_wdog_keyseq #(.DATA_W(DATA_W)) u_keyseq (
      .clk      (clk),
      .rst_n    (rst_n),
      .key_we   (bus_we && sel_key),
      .key_data (bus_wdata),
      .pair_done(pair_done)
   );

   win_wdog_window #(.CNT_W(CNT_W), .DATA_W(DATA_W), .NCODES(NCODES)) u_window (
      .win_code  (win_q),
      .reload_val(reload_val),
      .thresh    (thr_live)
   );

   win_wdog_core #(.CNT_W(CNT_W)) u_core (
      .clk       (clk),
      .rst_n     (rst_n),
      .arm       (bus_we && sel_ctl && bus_wdata == DATA_W'(ARM_WORD)),
      .pair_done (pair_done),
      .reload_val(reload_val),
      .thresh    (thr_q),
      .running   (running),
      .cnt       (cnt),
      .reload_ev (reload_ev),
      .viol_ev   (viol_ev)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pre_q     <= '1;
         win_q     <= DATA_W'(WIN_RESET);
         react_q   <= '0;
         stat_q    <= 1'b0;
         thr_q     <= '0;
         nmi_sel_q <= 1'b0;
         rst_req   <= 1'b0;
         nmi_req   <= 1'b0;
      end else begin
         if (bus_we && sel_pre)   pre_q   <= bus_wdata[PRE_W-1:0];
         if (bus_we && sel_win)   win_q   <= bus_wdata;
         if (bus_we && sel_react) react_q <= bus_wdata;
         if (viol_ev)
            stat_q <= 1'b1;
         else if (bus_we && sel_stat && bus_wdata[1])
            stat_q <= 1'b0;
         if (reload_ev) begin
            thr_q     <= thr_live;
            nmi_sel_q <= (react_q == DATA_W'(NMI_WORD));
         end
         rst_req <= viol_ev && !nmi_sel_q;
         nmi_req <= viol_ev && nmi_sel_q;
      end
   end

   always_comb begin
      bus_rdata = '0;
      if (sel_ctl)   bus_rdata = running ? DATA_W'(ARM_WORD) : '0;
      if (sel_pre)   bus_rdata = DATA_W'(pre_q);
      if (sel_stat)  bus_rdata = DATA_W'({stat_q, 1'b0});
      if (sel_react) bus_rdata = react_q;
      if (sel_win)   bus_rdata = win_q;
      if (bus_addr == ADDR_W'(OFF_CNT)) bus_rdata = DATA_W'(cnt);
   end
endmodule

// File: rtl/win_wdog_chk.sv
module win_wdog_chk #(
   parameter int CNT_W = 25
) (
   input logic             clk,
   input logic             rst_n,
   input logic             running,
   input logic [CNT_W-1:0] cnt,
   input logic             reload_ev,
   input logic             stat_q,
   input logic             rst_req,
   input logic             nmi_req
);
   p_run_sticky_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $past(running) |-> running);

   p_count_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(running) && !$past(reload_ev)) |-> (cnt == $past(cnt) - {{(CNT_W-1){1'b0}}, 1'b1}));

   p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(running) && !$past(reload_ev)) |-> $stable(cnt));

   p_viol_running_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (rst_req || nmi_req) |-> running);

   p_one_route_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({rst_req, nmi_req}));

   p_flag_on_viol_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (rst_req || nmi_req) |-> stat_q);
endmodule

bind win_wdog win_wdog_chk #(.CNT_W(CNT_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .running  (running),
   .cnt      (cnt),
   .reload_ev(reload_ev),
   .stat_q   (stat_q),
   .rst_req  (rst_req),
   .nmi_req  (nmi_req)
);

// File: tb/tb_win_wdog.sv
module tb_win_wdog;
   localparam int SH = 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  addr = 8'h00;
   logic        we = 1'b0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        rst_req, nmi_req;
   int          total = 0;
   int          bad = 0;

   always #10 clk = ~clk;   // 50 MHz

   win_wdog #(.PRE_SHIFT(SH)) dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_we(we),
      .bus_wdata(wdata), .bus_rdata(rdata), .rst_req(rst_req), .nmi_req(nmi_req)
   );

   // {preload, window code, wait cycles between key words}
   localparam int NV = 10;
   localparam logic [51:0] VEC [NV] = '{
      {12'd8,  32'h50,     8'd2},  {12'd8,  32'h50,     8'd15},
      {12'd8,  32'h50,     8'd14}, {12'd8,  32'h500,    8'd23},
      {12'd8,  32'h500,    8'd22}, {12'd16, 32'h5000,   8'd55},
      {12'd16, 32'h50000,  8'd58}, {12'd16, 32'h500000, 8'd61},
      {12'd8,  32'h123,    8'd14}, {12'd8,  32'h500,    8'd31}};

   function automatic int win_k(input logic [31:0] c);
      case (c)
         32'h500:    return 2;
         32'h5000:   return 3;
         32'h50000:  return 4;
         32'h500000: return 5;
         default:    return 1;
      endcase
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      addr = a; wdata = d; we = 1'b1;
      @(negedge clk);
      we = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      addr = a; #1; d = rdata;
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   initial begin
      #(20 * 150000);
      bad++;
      $display("FAIL watchdog timeout");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [31:0] v, v2;
      @(negedge clk);
      do_reset();

      // R10 reset state
      rd(8'h90, v); chk("R10 ctl", v, 0);
      rd(8'hA0, v); chk("R10 cnt", v, 0);
      rd(8'h98, v); chk("R10 stat", v, 0);
      rd(8'h94, v); chk("R10 pre", v, 32'hFFF);
      rd(8'hA8, v); chk("R10 win", v, 32'h50);
      rd(8'hA4, v); chk("R10 react", v, 0);
      chk("R10 pulses", {30'd0, rst_req, nmi_req}, 0);

      // R11 pair while stopped, R1 wrong arming word
      wr(8'h9C, 32'hE51A); wr(8'h9C, 32'hA35C);
      rd(8'h98, v); chk("R11 stat", v, 0);
      rd(8'hA0, v); chk("R11 cnt", v, 0);
      chk("R11 pulses", {30'd0, rst_req, nmi_req}, 0);
      wr(8'h90, 32'hA98559DB);
      rd(8'h90, v); chk("R1 wrong word", v, 0);
      wr(8'h94, 32'h1FFF);
      rd(8'h94, v); chk("R2 field width", v, 32'hFFF);

      // table walk: R4 / R5 window decision
      for (int i = 0; i < NV; i++) begin
         logic [11:0] pre; logic [31:0] code; int w, r, v_at, early;
         {pre, code, w} = {VEC[i][51:40], VEC[i][39:8], 24'd0, VEC[i][7:0]};
         w = int'(VEC[i][7:0]);
         r = int'(pre) << SH;
         v_at = r - 1 - w;
         early = (v_at > (r >> win_k(code))) ? 1 : 0;
         do_reset();
         wr(8'h94, {20'd0, pre});
         wr(8'hA8, code);
         wr(8'h90, 32'hA98559DA);
         wr(8'h9C, 32'hE51A);
         repeat (w) @(negedge clk);
         wr(8'h9C, 32'hA35C);
         chk(early ? "R5 early pulse" : "R4 in-window no pulse", {31'd0, rst_req}, early);
         rd(8'hA0, v); chk("R4 reload after pair", v, r);
         rd(8'h98, v); chk("R8 status after pair", v, early ? 2 : 0);
      end

      // R6 expiry, R9 deferred reaction, R7 routing and pulse width
      do_reset();
      wr(8'h94, 32'd2);
      wr(8'h90, 32'hA98559DA);
      rd(8'h90, v); chk("R1 ctl readback", v, 32'hA98559DA);
      wr(8'hA4, 32'hA);
      repeat (7) @(negedge clk);
      rd(8'hA0, v); chk("R6 at zero", v, 0);
      chk("R6 no pulse yet", {30'd0, rst_req, nmi_req}, 0);
      @(negedge clk);
      chk("R9 old reaction -> rst", {30'd0, rst_req, nmi_req}, 2);
      rd(8'hA0, v); chk("R6 reload", v, 8);
      rd(8'h98, v); chk("R8 set on expiry", v, 2);
      @(negedge clk);
      chk("R7 one cycle", {30'd0, rst_req, nmi_req}, 0);
      repeat (8) @(negedge clk);
      chk("R7 nmi route", {30'd0, rst_req, nmi_req}, 1);
      wr(8'h98, 32'h0);
      rd(8'h98, v); chk("R8 write 0 keeps", v, 2);
      wr(8'h98, 32'h2);
      rd(8'h98, v); chk("R8 w1c", v, 0);

      // R1 no stop
      wr(8'h90, 32'h0);
      rd(8'h90, v); chk("R1 no stop", v, 32'hA98559DA);
      rd(8'hA0, v); @(negedge clk); rd(8'hA0, v2);
      chk("R2 decrement", v2, v - 1);

      // R3 broken order
      do_reset();
      wr(8'h94, 32'd8);
      wr(8'h90, 32'hA98559DA);
      repeat (20) @(negedge clk);
      wr(8'h9C, 32'hE51A); wr(8'h9C, 32'h1234); wr(8'h9C, 32'hA35C);
      rd(8'hA0, v); chk("R3 broken no reload", v, 9);
      chk("R3 broken no pulse", {30'd0, rst_req, nmi_req}, 0);
      wr(8'h9C, 32'hE51A); wr(8'h9C, 32'hA35C);
      rd(8'hA0, v); chk("R3 recovered service", v, 32);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule